// File: doc/BRIEF.md
# Page Write Collector and Programming Sequencer

This block sits between a serial-memory command front end and the storage array of a small byte-addressed nonvolatile memory. When the front end decodes an array-write command, it announces the start address and then passes each received data byte as a strobe. The block keeps those bytes in a page-sized holding buffer. Only the low address bits, which give the offset inside the page, advance from byte to byte, so a long burst folds back to the start of the page and overwrites bytes already held. A per-slot valid mask records which slots received a byte in the current frame.

When chip select rises, the front end reports it with a pulse and says whether the frame ended on a whole byte. If the frame is armed, ended on a byte boundary, holds at least one byte and the protection block permits it, a self-timed programming cycle starts. During this cycle the busy flag stays high for a fixed number of system clocks. The marked bytes are copied into the array, and every new request is ignored. When the cycle ends, a one-clock done pulse lets the front end clear its write-enable latch. A status-register write uses the same timed cycle and hands its byte to the status logic at the end.

Top module: `page_write_seq`

## Requirements
- R1: While reset is high and just after it, `busy`, `cycle_done` and `sr_we` are 0.
- R2: A frame started at address A writes its k-th data byte (k from 0) to the address whose upper bits equal A's upper bits and whose low PAGE_W bits are (A + k) modulo the page size.
- R3: When a burst runs past the last slot of the page, it continues at slot 0 of the same page. A later byte for a slot replaces the earlier one, and no other page is touched.
- R4: Array locations in the page that received no byte in the frame keep their previous contents after the cycle.
- R5: A `cs_rise` pulse with `cs_on_boundary` low starts no cycle and changes no array location.
- R6: A `cs_rise` pulse with `wr_permit` low starts no cycle and changes no array location.
- R7: An accepted `cs_rise` makes `busy` 1 from the next clock for exactly WRITE_CYCLES clocks. `cycle_done` is 1 for one clock, in the first clock where `busy` is back to 0.
- R8: While `busy` is 1, start, data, status, chip-select and read requests are ignored. `rd_data` holds its value, and a frame sent during the cycle neither writes the array nor starts a new cycle.
- R9: A status frame (one `sr_byte_vld` strobe, then an accepted `cs_rise`) runs a full timed cycle. It leaves the array untouched and pulses `sr_we` together with `cycle_done`, with `sr_wdata` equal to the received byte.
- R10: An array frame that received no data byte starts no cycle on `cs_rise`.
- R11: Once `busy` is 0, a read with `rd_en` high returns the committed byte of `rd_addr` on `rd_data` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Pulse: array-write frame begins at `wr_addr` |
| wr_addr | input | ADDR_W | Start byte address of the array write |
| wr_byte_vld | input | 1 | Pulse: one data byte received |
| wr_byte | input | 8 | Data byte for the array |
| sr_byte_vld | input | 1 | Pulse: status-write byte received (arms a status frame) |
| sr_byte | input | 8 | Byte destined for the status register |
| cs_rise | input | 1 | Pulse: chip select went high |
| cs_on_boundary | input | 1 | Frame ended after a whole number of bytes |
| wr_permit | input | 1 | Protection block allows the pending write |
| rd_en | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Read data, one clock after the request |
| busy | output | 1 | Programming cycle in progress |
| cycle_done | output | 1 | One-clock pulse at the end of a cycle |
| sr_we | output | 1 | One-clock status-register update strobe |
| sr_wdata | output | 8 | Byte for the status register |

## Verification
The bench builds the block with ADDR_W=8, PAGE_W=4 and WRITE_CYCLES=40. The short cycle lets the bench count every busy clock and place its requests inside the window. The 256-byte array holds sixteen 16-slot pages, so the bench can fill two whole pages, fold a burst of eighteen bytes across a page end, and confirm that the neighbouring page is unchanged. Rejected frames (misaligned, denied or empty) and a frame sent during a cycle are each followed by read-back through the normal read port.

// File: rtl/page_write_pkg.sv
package page_write_pkg;
  typedef enum logic [0:0] {
    OP_ARRAY  = 1'b0,
    OP_STATUS = 1'b1
  } op_kind_t;
endpackage

// File: rtl/pws_frame_buf.sv
module pws_frame_buf #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [PAGE_W-1:0] sel_idx,
  output logic [7:0]        sel_data,
  output logic              sel_mask,
  output logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic              any_byte
);
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [7:0]        data_q [PAGE];
  logic [PAGE-1:0]   mask_q;
  logic [PAGE_W-1:0] offs_q;
  logic [BASE_W-1:0] base_q;

  // control: offset wraps inside the page, upper bits frozen per frame
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      offs_q <= '0;
      base_q <= '0;
    end else if (start) begin
      base_q <= start_addr[ADDR_W-1:PAGE_W];
      offs_q <= start_addr[PAGE_W-1:0];
      mask_q <= '0;
    end else if (byte_vld) begin
      mask_q[offs_q] <= 1'b1;
      offs_q         <= offs_q + 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (byte_vld && !start) data_q[offs_q] <= byte_data;
  end

  assign sel_data  = data_q[sel_idx];
  assign sel_mask  = mask_q[sel_idx];
  assign page_base = base_q;
  assign any_byte  = |mask_q;
endmodule

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer #(
  parameter int WRITE_CYCLES = 250000,
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  output logic             busy,
  output logic             done,
  output logic             last,
  output logic [CNT_W-1:0] step
);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(WRITE_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (step == END_CNT) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else if (launch) begin
        busy <= 1'b1;
        step <= '0;
      end
    end
  end

  assign last = busy && (step == END_CNT);
endmodule

// File: rtl/pws_array_ram.sv
module pws_array_ram #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import page_write_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_byte_vld,
  input  logic [7:0]        wr_byte,
  input  logic              sr_byte_vld,
  input  logic [7:0]        sr_byte,
  input  logic              cs_rise,
  input  logic              cs_on_boundary,
  input  logic              wr_permit,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              cycle_done,
  output logic              sr_we,
  output logic [7:0]        sr_wdata
);
  localparam int CNT_W  = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam int BASE_W = ADDR_W - PAGE_W;

  op_kind_t          op_q;
  logic              armed_q;
  logic              idle;
  logic              buf_start, buf_byte, launch;
  logic [7:0]        sel_data;
  logic              sel_mask, any_byte, tmr_last;
  logic [BASE_W-1:0] page_base;
  logic [CNT_W-1:0]  step;
  logic              in_page, ram_we;

  assign idle      = !busy;
  assign buf_start = idle && wr_start && !cs_rise;
  assign buf_byte  = idle && wr_byte_vld && armed_q && (op_q == OP_ARRAY)
                     && !wr_start && !cs_rise;
  assign launch    = idle && cs_rise && cs_on_boundary && wr_permit && armed_q
                     && ((op_q == OP_STATUS) || any_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      op_q     <= OP_ARRAY;
      sr_wdata <= '0;
      sr_we    <= 1'b0;
    end else begin
      sr_we <= tmr_last && (op_q == OP_STATUS);
      if (idle) begin
        if (cs_rise) begin
          armed_q <= 1'b0;
        end else if (wr_start) begin
          armed_q <= 1'b1;
          op_q    <= OP_ARRAY;
        end else if (sr_byte_vld) begin
          armed_q  <= 1'b1;
          op_q     <= OP_STATUS;
          sr_wdata <= sr_byte;
        end
      end
    end
  end

  pws_frame_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) frame_i (
    .clk        (clk),
    .rst        (rst),
    .start      (buf_start),
    .start_addr (wr_addr),
    .byte_vld   (buf_byte),
    .byte_data  (wr_byte),
    .sel_idx    (step[PAGE_W-1:0]),
    .sel_data   (sel_data),
    .sel_mask   (sel_mask),
    .page_base  (page_base),
    .any_byte   (any_byte)
  );

  pws_cycle_timer #(.WRITE_CYCLES(WRITE_CYCLES)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .busy   (busy),
    .done   (cycle_done),
    .last   (tmr_last),
    .step   (step)
  );

  // program one buffered slot per clock during the first PAGE clocks of the cycle
  assign in_page = (step >> PAGE_W) == '0;
  assign ram_we  = busy && in_page && sel_mask && (op_q == OP_ARRAY);

  pws_array_ram #(.ADDR_W(ADDR_W)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr ({page_base, step[PAGE_W-1:0]}),
    .wdata (sel_data),
    .re    (rd_en && idle),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk #(
  parameter int WRITE_CYCLES = 250000
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_rise,
  input logic       cs_on_boundary,
  input logic       wr_permit,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       cycle_done,
  input logic       sr_we
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == WRITE_CYCLES));

  // R7
  done_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cycle_done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_done |=> !cycle_done);

  // R5
  misaligned_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !cs_on_boundary && !busy) |=> !busy);

  // R6
  denied_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !wr_permit && !busy) |=> !busy);

  // R9
  sr_we_chk: assert property (@(posedge clk) disable iff (rst)
    sr_we |-> cycle_done);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_en) |=> $stable(rd_data));
endmodule

bind page_write_seq page_write_seq_chk #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .cs_rise        (cs_rise),
  .cs_on_boundary (cs_on_boundary),
  .wr_permit      (wr_permit),
  .rd_en          (rd_en),
  .rd_data        (rd_data),
  .busy           (busy),
  .cycle_done     (cycle_done),
  .sr_we          (sr_we)
);

// File: tb/page_write_seq_tb_top.sv
`timescale 1ns/1ps
module page_write_seq_tb_top;
  localparam int AW = 8;
  localparam int PW = 4;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 0, wr_byte_vld = 0, sr_byte_vld = 0, cs_rise = 0;
  logic cs_on_boundary = 1, wr_permit = 1, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_byte = '0, sr_byte = '0;
  logic [7:0] rd_data, sr_wdata;
  logic busy, cycle_done, sr_we;

  always #10 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
    .wr_byte_vld(wr_byte_vld), .wr_byte(wr_byte), .sr_byte_vld(sr_byte_vld),
    .sr_byte(sr_byte), .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
    .wr_permit(wr_permit), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .cycle_done(cycle_done), .sr_we(sr_we), .sr_wdata(sr_wdata)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_mem [256];
  logic [7:0] pend_d [16];
  bit         pend_m [16];
  logic [3:0] pend_base;

  logic [7:0] sb_exp [$];
  string      sb_tag [$];
  logic       rd_fire = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against scoreboard
  always @(posedge clk) rd_fire <= rd_en && !busy;
  always @(negedge clk) begin
    if (rd_fire && sb_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = sb_exp.pop_front();
      t = sb_tag.pop_front();
      chk(rd_data === e, t, {24'h0, rd_data}, {24'h0, e});
    end
  end

  task automatic rd_check(input logic [7:0] a, input string tag);
    sb_exp.push_back(exp_mem[a]);
    sb_tag.push_back(tag);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic start_frame(input logic [7:0] a);
    @(negedge clk); wr_start = 1; wr_addr = a;
    @(negedge clk); wr_start = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); wr_byte_vld = 1; wr_byte = d;
    @(negedge clk); wr_byte_vld = 0;
  endtask

  task automatic end_frame(input bit aligned, input bit permit);
    @(negedge clk); cs_rise = 1; cs_on_boundary = aligned; wr_permit = permit;
    @(negedge clk); cs_rise = 0; cs_on_boundary = 1; wr_permit = 1;
  endtask

  task automatic frame(input logic [7:0] a, input int n, input logic [7:0] first);
    logic [3:0] off;
    for (int i = 0; i < 16; i++) pend_m[i] = 0;
    pend_base = a[7:4];
    off = a[3:0];
    start_frame(a);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i));
      pend_d[off] = first + 8'(i);
      pend_m[off] = 1;
      off = off + 4'd1;
    end
  endtask

  task automatic commit();
    for (int i = 0; i < 16; i++)
      if (pend_m[i]) exp_mem[{pend_base, 4'(i)}] = pend_d[i];
  endtask

  task automatic run_cycle(input int already, input bit exp_sr, input logic [7:0] exp_srd, input string tag);
    int n;
    n = already;
    while (busy === 1'b1 && n < WC + 10) begin
      n++;
      @(negedge clk);
    end
    chk(n == WC, tag, n, WC);
    chk(cycle_done === 1'b1, tag, cycle_done, 1);
    chk(sr_we === exp_sr, tag, sr_we, exp_sr);
    if (exp_sr) chk(sr_wdata === exp_srd, tag, sr_wdata, exp_srd);
    @(negedge clk);
    chk(cycle_done === 1'b0, tag, cycle_done, 0);
  endtask

  task automatic no_cycle(input string tag);
    bit seen;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (busy !== 1'b0) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin : main
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", busy, 0);
    chk(cycle_done === 1'b0, "R1", cycle_done, 0);
    chk(sr_we === 1'b0, "R1", sr_we, 0);
    rst = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R1", busy, 0);

    // R2 / R7 / R11: two full pages
    frame(8'h20, 16, 8'h10); end_frame(1, 1);
    chk(busy === 1'b1, "R7", busy, 1);
    run_cycle(0, 0, 8'h00, "R7"); commit();
    frame(8'h30, 16, 8'h40); end_frame(1, 1);
    run_cycle(0, 0, 8'h00, "R7"); commit();
    for (int a = 8'h20; a < 8'h30; a++) rd_check(8'(a), "R2");
    for (int a = 8'h30; a < 8'h40; a++) rd_check(8'(a), "R11");

    // R4: partial frame leaves other slots alone
    frame(8'h25, 3, 8'hA0); end_frame(1, 1);
    run_cycle(0, 0, 8'h00, "R4"); commit();
    for (int a = 8'h23; a < 8'h2A; a++) rd_check(8'(a), "R4");

    // R3: 18 bytes from offset 14 fold inside page 3
    frame(8'h3E, 18, 8'hC0); end_frame(1, 1);
    run_cycle(0, 0, 8'h00, "R3"); commit();
    chk(exp_mem[8'h3E] === 8'hD0, "R3", exp_mem[8'h3E], 8'hD0);
    rd_check(8'h3E, "R3"); rd_check(8'h3F, "R3");
    rd_check(8'h30, "R3"); rd_check(8'h3D, "R3");
    rd_check(8'h2F, "R3"); rd_check(8'h20, "R3");

    // R5: misaligned end of frame
    frame(8'h20, 1, 8'hEE); end_frame(0, 1);
    no_cycle("R5"); rd_check(8'h20, "R5");

    // R6: protection denies
    frame(8'h21, 1, 8'hDD); end_frame(1, 0);
    no_cycle("R6"); rd_check(8'h21, "R6");

    // R10: frame with no data
    start_frame(8'h22); end_frame(1, 1);
    no_cycle("R10"); rd_check(8'h22, "R10");

    // R8: requests during the cycle are ignored
    frame(8'h21, 1, 8'h55); end_frame(1, 1);
    held = rd_data;
    start_frame(8'h23);
    send_byte(8'h99);
    @(negedge clk); rd_en = 1; rd_addr = 8'h3E;
    @(negedge clk); rd_en = 0;
    end_frame(1, 1);
    chk(rd_data === held, "R8", rd_data, held);
    run_cycle(8, 0, 8'h00, "R8"); commit();
    no_cycle("R8");
    rd_check(8'h21, "R8"); rd_check(8'h23, "R8");

    // R9: status write through the timed cycle
    @(negedge clk); sr_byte_vld = 1; sr_byte = 8'h8C;
    @(negedge clk); sr_byte_vld = 0;
    end_frame(1, 1);
    run_cycle(0, 1, 8'h8C, "R9");
    rd_check(8'h20, "R9"); rd_check(8'h30, "R9");

    repeat (3) @(negedge clk);
    chk(sb_exp.size() == 0, "R11", sb_exp.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule